// File: doc/BRIEF.md
# Scale-Space Local Maximum Marker

This block sits behind a Hessian-determinant generator in a feature detector. The determinants arrive as a stream of blocks. Each block covers one 2x2 pixel area and carries one determinant per pixel for every scale of the octave. The marker keeps three blocks in rotating local slots. Each completed block is examined once its successor has fully arrived. A determinant becomes a candidate when it is strictly above a programmable threshold and strictly above every scale-space neighbour that the marker can see. The visible neighbours are those inside the examined block and, when the successor block sits directly to its right, the successor's left pixel column.

Candidates are packed with their pixel coordinates, scale index and Laplacian sign and written into an output FIFO. Software reads the FIFO one entry at a time. An interrupt line rises when the FIFO holds at least a programmed number of entries. The suppression is deliberately incomplete, because rows above and below are never compared. The candidate set is therefore a superset of the true maxima, and software re-examines every entry and also performs the sub-pixel refinement.

Top module: `ssmax_marker`

## Requirements
- R1: A determinant is marked only if its value is strictly greater than `thr`. A value equal to `thr` is not marked.
- R2: A determinant is marked only if it is strictly greater than every other determinant of its own block whose scale differs from its own by at most one. This covers all four pixels of the 2x2 area. An equal value disqualifies it.
- R3: The next block counts as adjacent when its `in_y` equals the examined block's `in_y` and its `in_x` is the examined block's `in_x` plus 2. Only then are the right-column pixels (pixel 1 and pixel 3) of the examined block also compared, with the same strict rule and the same scale window, against the left-column pixels (pixel 0 and pixel 2) of the next block. A next block that is not adjacent has no effect on the outcome.
- R4: Determinants at scale 0 and at scale NS-1 are never marked.
- R5: A block is delivered as 4*NS beats. Beat k carries scale k/4 and pixel k mod 4. The pixels are ordered (0,0), (1,0), (0,1), (1,1), given as (dx,dy) from the block's top-left pixel (`in_x`, `in_y`, with `in_x` even). A block is examined when the following block completes. Its candidates enter the FIFO in beat order, and candidates from successive blocks enter in arrival order.
- R6: A FIFO entry is 24 bits wide. Bits 23:14 hold the pixel x (`in_x`+dx), bits 13:4 hold the pixel y (`in_y`+dy), bits 3:1 hold the scale index, and bit 0 holds the Laplacian sign delivered with that determinant.
- R7: `rd_data` shows the oldest entry whenever `rd_valid` is high, and `rd_en` removes it. `rd_en` on an empty FIFO has no effect.
- R8: `irq` is high exactly while the FIFO holds at least `irq_level` entries. An `irq_level` of 0 keeps `irq` low.
- R9: A candidate that finds the FIFO holding DEPTH entries is dropped, and `ovf` is set. `ovf` then stays high until reset.
- R10: After reset the FIFO is empty, `rd_valid`, `irq` and `ovf` are low, and no block is buffered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Determinant beat valid |
| in_det | input | DW | Unsigned determinant value |
| in_sign | input | 1 | Laplacian sign of this determinant |
| in_x | input | 10 | Top-left pixel x of the current block (even) |
| in_y | input | 10 | Top-left pixel y of the current block |
| thr | input | DW | Detection threshold |
| rd_en | input | 1 | Pop the oldest FIFO entry |
| irq_level | input | $clog2(DEPTH+1) | Fill level that raises the interrupt |
| rd_data | output | 24 | Oldest FIFO entry |
| rd_valid | output | 1 | FIFO not empty |
| irq | output | 1 | Fill-level interrupt |
| ovf | output | 1 | Sticky overflow flag |

## Verification
Several properties are checked on every cycle: the FIFO count never exceeds its depth; the overflow flag never falls once set and only rises on a dropped push; a pop on an empty FIFO leaves it empty; an evaluation never starts while another is still in flight; and no pushed entry carries an edge scale. Whether a given determinant is right to be marked can only be shown by the bench scenarios. These compare the popped entries against a coordinate-based neighbourhood model for threshold equality, ties inside a block, ties against an adjacent or a misaligned next block, and edge-scale peaks. A chain of adjacent blocks shows arrival order, the interrupt level crossing, the drops on a full FIFO and the sticky flag.

// File: rtl/ssmax_pkg.sv
package ssmax_pkg;

  // One FIFO entry: x in [23:14], y in [13:4], scale in [3:1], sign in [0].
  typedef struct packed {
    logic [9:0] x;
    logic [9:0] y;
    logic [2:0] scale;
    logic       sign;
  } mark_t;

  // Two scale indices are neighbours when they differ by at most one.
  function automatic logic scale_close(int a, int b);
    return ((a - b) <= 1) && ((b - a) <= 1);
  endfunction

  // Pixel p of a block: dx = p mod 2, dy = p / 2.
  function automatic mark_t pack_mark(logic [9:0] bx, logic [9:0] by,
                                      int p, int s, logic sg);
    mark_t m;
    m.x     = bx + 10'(p % 2);
    m.y     = by + 10'(p / 2);
    m.scale = 3'(s);
    m.sign  = sg;
    return m;
  endfunction

endpackage

// File: rtl/ssmax_blkbuf.sv
module ssmax_blkbuf #(
  parameter int NS = 4,
  parameter int DW = 16,
  localparam int NB = 4 * NS,
  localparam int BW = $clog2(NB)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic [DW-1:0] in_det,
  input  logic          in_sign,
  input  logic [9:0]    in_x,
  input  logic [9:0]    in_y,
  output logic [DW-1:0] slot_det [3][NB],
  output logic          slot_sgn [3][NB],
  output logic [9:0]    slot_x [3],
  output logic [9:0]    slot_y [3],
  output logic          blk_done,
  output logic [1:0]    cur_slot,
  output logic [1:0]    prv_slot,
  output logic          have_prev
);

  logic [BW-1:0] beat;

  assign blk_done = in_valid && (beat == BW'(NB - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      beat      <= '0;
      cur_slot  <= 2'd0;
      prv_slot  <= 2'd2;
      have_prev <= 1'b0;
    end else if (in_valid) begin
      beat <= blk_done ? '0 : beat + 1'b1;
      if (blk_done) begin
        prv_slot  <= cur_slot;
        cur_slot  <= (cur_slot == 2'd2) ? 2'd0 : cur_slot + 2'd1;
        have_prev <= 1'b1;
      end
    end
  end

  // Storage carries no reset: a slot is only read after it is fully written.
  always_ff @(posedge clk) begin
    if (in_valid) begin
      slot_det[cur_slot][beat] <= in_det;
      slot_sgn[cur_slot][beat] <= in_sign;
      slot_x[cur_slot]         <= in_x;
      slot_y[cur_slot]         <= in_y;
    end
  end

  // R5: the slot being written is never the slot kept as the previous block
  p_slots_apart_r5: assert property (@(posedge clk) disable iff (!rst_n)
    have_prev |-> (cur_slot != prv_slot) && (cur_slot < 2'd3) && (prv_slot < 2'd3));

endmodule

// File: rtl/ssmax_eval.sv
module ssmax_eval
  import ssmax_pkg::*;
#(
  parameter int NS = 4,
  parameter int DW = 16,
  localparam int NB = 4 * NS,
  localparam int BW = $clog2(NB)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [DW-1:0] slot_det [3][NB],
  input  logic          slot_sgn [3][NB],
  input  logic [9:0]    slot_x [3],
  input  logic [9:0]    slot_y [3],
  input  logic [DW-1:0] thr,
  input  logic          blk_done,
  input  logic [1:0]    cur_slot,
  input  logic [1:0]    prv_slot,
  input  logic          have_prev,
  output logic          push,
  output mark_t         push_mark
);

  logic          active;
  logic [BW-1:0] idx;
  logic [1:0]    es;      // examined block
  logic [1:0]    ns;      // its successor
  logic          start;
  logic          adj;
  logic          cand;
  logic [DW-1:0] here;
  int            s_i;
  int            p_i;

  assign start = blk_done && have_prev;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active <= 1'b0;
      idx    <= '0;
      es     <= 2'd0;
      ns     <= 2'd0;
    end else if (start) begin
      active <= 1'b1;
      idx    <= '0;
      es     <= prv_slot;
      ns     <= cur_slot;
    end else if (active) begin
      if (idx == BW'(NB - 1)) begin
        active <= 1'b0;
        idx    <= '0;
      end else begin
        idx <= idx + 1'b1;
      end
    end
  end

  assign adj = (slot_y[ns] == slot_y[es]) && (slot_x[ns] == slot_x[es] + 10'd2);

  always_comb begin
    s_i  = int'(idx >> 2);
    p_i  = int'(idx[1:0]);
    here = slot_det[es][idx];
    cand = active && (here > thr) && (s_i != 0) && (s_i != NS - 1);
    for (int j = 0; j < NB; j++) begin
      if ((j != int'(idx)) && scale_close(j / 4, s_i) && (slot_det[es][j] >= here))
        cand = 1'b0;
      if (adj && (p_i % 2 == 1) && (j % 2 == 0) && scale_close(j / 4, s_i) &&
          (slot_det[ns][j] >= here))
        cand = 1'b0;
    end
  end

  assign push      = cand;
  assign push_mark = pack_mark(slot_x[es], slot_y[es], p_i, s_i, slot_sgn[es][idx]);

  // R5: a new evaluation never cuts into an unfinished one
  p_no_overlap_r5: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> (!active || (idx == BW'(NB - 1))));

  // R4: no entry leaves with an edge scale
  p_edge_scale_r4: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> (push_mark.scale != 3'd0) && (push_mark.scale != 3'(NS - 1)));

endmodule

// File: rtl/ssmax_fifo.sv
module ssmax_fifo #(
  parameter int W = 24,
  parameter int DEPTH = 8,
  localparam int AW = $clog2(DEPTH),
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [W-1:0]  wdata,
  input  logic          pop,
  input  logic [CW-1:0] level,
  output logic [W-1:0]  rdata,
  output logic          nonempty,
  output logic          irq,
  output logic          ovf
);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wptr;
  logic [AW-1:0] rptr;
  logic [CW-1:0] count;
  logic          full;
  logic          acc;
  logic          take;

  assign full     = (count == CW'(DEPTH));
  assign acc      = push && !full;
  assign take     = pop && (count != '0);
  assign nonempty = (count != '0);
  assign rdata    = mem[rptr];
  assign irq      = (level != '0) && (count >= level);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wptr  <= '0;
      rptr  <= '0;
      count <= '0;
      ovf   <= 1'b0;
    end else begin
      if (acc)
        wptr <= (wptr == AW'(DEPTH - 1)) ? '0 : wptr + 1'b1;
      if (take)
        rptr <= (rptr == AW'(DEPTH - 1)) ? '0 : rptr + 1'b1;
      count <= count + CW'(acc) - CW'(take);
      if (push && full)
        ovf <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (acc)
      mem[wptr] <= wdata;
  end

  // R9: occupancy never passes the depth
  p_count_bound_r9: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CW'(DEPTH));

  // R9: the overflow flag is sticky
  p_ovf_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ovf |=> ovf);

  // R9: the flag rises only after a push met a full FIFO
  p_ovf_cause_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovf) |-> $past(push && full));

  // R7: popping an empty FIFO leaves it empty
  p_empty_pop_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && (count == '0) && !push) |=> (count == '0));

endmodule

// File: rtl/ssmax_marker.sv
module ssmax_marker
  import ssmax_pkg::*;
#(
  parameter int NS = 4,
  parameter int DW = 16,
  parameter int DEPTH = 8,
  localparam int NB = 4 * NS,
  localparam int LW = $clog2(DEPTH + 1),
  localparam int MW = $bits(mark_t)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic [DW-1:0] in_det,
  input  logic          in_sign,
  input  logic [9:0]    in_x,
  input  logic [9:0]    in_y,
  input  logic [DW-1:0] thr,
  input  logic          rd_en,
  input  logic [LW-1:0] irq_level,
  output logic [MW-1:0] rd_data,
  output logic          rd_valid,
  output logic          irq,
  output logic          ovf
);

  logic [DW-1:0] slot_det [3][NB];
  logic          slot_sgn [3][NB];
  logic [9:0]    slot_x [3];
  logic [9:0]    slot_y [3];
  logic          blk_done;
  logic [1:0]    cur_slot;
  logic [1:0]    prv_slot;
  logic          have_prev;
  logic          push;
  mark_t         push_mark;

  ssmax_blkbuf #(.NS(NS), .DW(DW)) buf_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_det(in_det),
    .in_sign(in_sign), .in_x(in_x), .in_y(in_y),
    .slot_det(slot_det), .slot_sgn(slot_sgn), .slot_x(slot_x), .slot_y(slot_y),
    .blk_done(blk_done), .cur_slot(cur_slot), .prv_slot(prv_slot),
    .have_prev(have_prev)
  );

  ssmax_eval #(.NS(NS), .DW(DW)) eval_i (
    .clk(clk), .rst_n(rst_n),
    .slot_det(slot_det), .slot_sgn(slot_sgn), .slot_x(slot_x), .slot_y(slot_y),
    .thr(thr), .blk_done(blk_done), .cur_slot(cur_slot), .prv_slot(prv_slot),
    .have_prev(have_prev), .push(push), .push_mark(push_mark)
  );

  ssmax_fifo #(.W(MW), .DEPTH(DEPTH)) fifo_i (
    .clk(clk), .rst_n(rst_n), .push(push), .wdata(push_mark), .pop(rd_en),
    .level(irq_level), .rdata(rd_data), .nonempty(rd_valid), .irq(irq), .ovf(ovf)
  );

endmodule

// File: tb/ssmax_marker_tb_top.sv
`timescale 1ns/1ps
module ssmax_marker_tb_top;

  localparam int NS = 4;
  localparam int DW = 16;
  localparam int DEPTH = 8;
  localparam int NB = 4 * NS;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic [DW-1:0] in_det = '0;
  logic in_sign = 1'b0;
  logic [9:0] in_x = '0;
  logic [9:0] in_y = '0;
  logic [DW-1:0] thr = '0;
  logic rd_en = 1'b0;
  logic [3:0] irq_level = '0;
  logic [23:0] rd_data;
  logic rd_valid, irq, ovf;

  always #10 clk = ~clk;

  ssmax_marker #(.NS(NS), .DW(DW), .DEPTH(DEPTH)) dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_det(in_det),
    .in_sign(in_sign), .in_x(in_x), .in_y(in_y), .thr(thr), .rd_en(rd_en),
    .irq_level(irq_level), .rd_data(rd_data), .rd_valid(rd_valid),
    .irq(irq), .ovf(ovf)
  );

  int total = 0;
  int bad = 0;
  bit finished = 0;

  // staging block, previous block and expected entries
  logic [DW-1:0] bd [NB];
  logic          bs [NB];
  logic [DW-1:0] pd [NB];
  logic          ps [NB];
  logic [9:0]    m_x, m_y;
  bit            m_have = 0;
  logic [23:0]   exq [256];
  int            exw = 0;
  int            exr = 0;
  bit            exp_ovf = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int iabs(int a);
    return (a < 0) ? -a : a;
  endfunction

  task automatic fill(input logic [DW-1:0] v);
    for (int k = 0; k < NB; k++) begin
      bd[k] = v;
      bs[k] = 1'b0;
    end
  endtask

  task automatic put(input int s, input int p, input logic [DW-1:0] v, input bit g);
    bd[s * 4 + p] = v;
    bs[s * 4 + p] = g;
  endtask

  // neighbourhood model by coordinates: previous block at (m_x,m_y), new block at (nx,ny)
  task automatic model_eval(input logic [9:0] nx, input logic [9:0] ny);
    bit adj;
    adj = (ny == m_y) && (nx == m_x + 10'd2);
    for (int s = 0; s < NS; s++) begin
      for (int p = 0; p < 4; p++) begin
        logic [DW-1:0] v;
        bit ok;
        v  = pd[s * 4 + p];
        ok = (v > thr) && (s > 0) && (s < NS - 1);
        for (int s2 = 0; s2 < NS; s2++) begin
          for (int p2 = 0; p2 < 4; p2++) begin
            int ds, dx, dy, dxn;
            ds  = s2 - s;
            dx  = (p2 % 2) - (p % 2);
            dy  = (p2 / 2) - (p / 2);
            dxn = (p2 % 2) + 2 - (p % 2);
            if (!(ds == 0 && dx == 0 && dy == 0) && iabs(ds) <= 1 && iabs(dx) <= 1 &&
                iabs(dy) <= 1 && pd[s2 * 4 + p2] >= v)
              ok = 0;
            if (adj && iabs(ds) <= 1 && iabs(dxn) <= 1 && iabs(dy) <= 1 &&
                bd[s2 * 4 + p2] >= v)
              ok = 0;
          end
        end
        if (ok) begin
          if (exw - exr < DEPTH) begin
            exq[exw % 256] = {10'(m_x + 10'(p % 2)), 10'(m_y + 10'(p / 2)), 3'(s), ps[s * 4 + p]};
            exw++;
          end else begin
            exp_ovf = 1;
          end
        end
      end
    end
  endtask

  task automatic send_block(input logic [9:0] nx, input logic [9:0] ny);
    for (int k = 0; k < NB; k++) begin
      @(negedge clk);
      in_valid = 1'b1;
      in_det   = bd[k];
      in_sign  = bs[k];
      in_x     = nx;
      in_y     = ny;
    end
    @(negedge clk);
    in_valid = 1'b0;
    if (m_have) model_eval(nx, ny);
    for (int k = 0; k < NB; k++) begin
      pd[k] = bd[k];
      ps[k] = bs[k];
    end
    m_x = nx;
    m_y = ny;
    m_have = 1;
  endtask

  // all-zero, non-adjacent block: closes evaluation of the previous block
  task automatic closer();
    fill('0);
    send_block(10'd900, 10'd900);
  endtask

  task automatic settle();
    repeat (NB + 4) @(negedge clk);
  endtask

  task automatic drain(input int want, input string req);
    settle();
    chk((exw - exr) == want, req, "candidate count", exw - exr, want);
    chk(irq == ((irq_level != 0) && ((exw - exr) >= int'(irq_level))), "R8",
        "irq before drain", int'(irq), int'((irq_level != 0) && ((exw - exr) >= int'(irq_level))));
    chk(ovf == exp_ovf, "R9", "ovf flag", int'(ovf), int'(exp_ovf));
    while (exr < exw) begin
      chk(rd_valid == 1'b1, "R7", "rd_valid with data", int'(rd_valid), 1);
      chk(rd_data == exq[exr % 256], "R6", "entry", int'(rd_data), int'(exq[exr % 256]));
      rd_en = 1'b1;
      @(negedge clk);
      rd_en = 1'b0;
      exr++;
    end
    chk(rd_valid == 1'b0, "R7", "empty after drain", int'(rd_valid), 0);
    chk(irq == 1'b0, "R8", "irq after drain", int'(irq), 0);
  endtask

  task automatic t_reset();
    chk(rd_valid == 1'b0, "R10", "rd_valid after reset", int'(rd_valid), 0);
    chk(irq == 1'b0, "R10", "irq after reset", int'(irq), 0);
    chk(ovf == 1'b0, "R10", "ovf after reset", int'(ovf), 0);
  endtask

  // single peak at a right-column pixel, then level 0 vs level 1, then empty pop
  task automatic t_single_peak();
    thr = 16'd50;
    irq_level = 4'd0;
    fill(16'd20); put(1, 3, 16'd900, 1'b1);
    send_block(10'd10, 10'd4);
    fill(16'd20);
    send_block(10'd12, 10'd4);
    settle();
    chk(rd_valid == 1'b1, "R2", "peak marked", int'(rd_valid), 1);
    chk(rd_data[23:14] == 10'd11, "R6", "x field", int'(rd_data[23:14]), 11);
    chk(rd_data[13:4] == 10'd5, "R6", "y field", int'(rd_data[13:4]), 5);
    chk(rd_data[3:1] == 3'd1, "R6", "scale field", int'(rd_data[3:1]), 1);
    chk(rd_data[0] == 1'b1, "R6", "sign field", int'(rd_data[0]), 1);
    chk(irq == 1'b0, "R8", "level 0 keeps irq low", int'(irq), 0);
    irq_level = 4'd1;
    @(negedge clk);
    chk(irq == 1'b1, "R8", "level 1 with one entry", int'(irq), 1);
    closer();
    drain(1, "R2");
    rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
    @(negedge clk);
    chk(rd_valid == 1'b0, "R7", "pop on empty ignored", int'(rd_valid), 0);
  endtask

  task automatic t_tie_in_block();
    thr = 16'd50;
    fill(16'd20); put(2, 0, 16'd700, 1'b0); put(1, 2, 16'd700, 1'b1);
    send_block(10'd40, 10'd30);
    closer();
    drain(0, "R2");
  endtask

  task automatic t_adjacent_tie();
    thr = 16'd50;
    fill(16'd20); put(2, 1, 16'd800, 1'b0);
    send_block(10'd20, 10'd8);
    fill(16'd20); put(2, 2, 16'd800, 1'b1);
    send_block(10'd22, 10'd8);
    closer();
    drain(1, "R3");
  endtask

  task automatic t_misaligned_next();
    thr = 16'd50;
    fill(16'd20); put(1, 1, 16'd800, 1'b1);
    send_block(10'd30, 10'd8);
    fill(16'd20); put(1, 0, 16'd900, 1'b0);
    send_block(10'd32, 10'd10);
    closer();
    drain(2, "R3");
  endtask

  task automatic t_threshold();
    thr = 16'd100;
    fill(16'd10); put(1, 0, 16'd100, 1'b0);
    send_block(10'd50, 10'd2);
    fill(16'd10); put(2, 3, 16'd101, 1'b1);
    send_block(10'd52, 10'd2);
    closer();
    drain(1, "R1");
  endtask

  task automatic t_edge_scale();
    thr = 16'd50;
    fill(16'd20); put(0, 1, 16'd900, 1'b0); put(NS - 1, 2, 16'd900, 1'b1);
    send_block(10'd60, 10'd12);
    closer();
    drain(0, "R4");
  endtask

  task automatic t_chain_overflow();
    thr = 16'd50;
    irq_level = 4'd3;
    for (int k = 0; k < 11; k++) begin
      fill(16'd20); put(1, 0, 16'(1000 + k), k[0]);
      send_block(10'(100 + 2 * k), 10'd20);
      if (k == 2) begin
        settle();
        chk(irq == 1'b0, "R8", "two entries below level 3", int'(irq), 0);
      end
      if (k == 3) begin
        settle();
        chk(irq == 1'b1, "R8", "three entries reach level 3", int'(irq), 1);
      end
    end
    closer();
    drain(DEPTH, "R5");
    chk(ovf == 1'b1, "R9", "ovf sticky after drain", int'(ovf), 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_single_peak();
    t_tie_in_block();
    t_adjacent_tie();
    t_misaligned_next();
    t_threshold();
    t_edge_scale();
    t_chain_overflow();
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog run did not complete actual=0 expected=1");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule